// File: doc/BRIEF.md
# Mode-Switching Indirect Jump Unit

This block carries out a register-indirect jump for a processor core that runs in one of two address modes: a 16-bit mode, where addresses are formed from an 8-bit base byte and a 16-bit offset, and a 24-bit flat mode. Instruction bytes arrive on a valid/ready byte stream. An optional size-override prefix byte can come in front of the jump opcode. The unit holds the 24-bit program counter, the mode bit and the base byte. When it completes a jump, it loads the program counter from a 24-bit pointer input, updates the mode bit, raises a one-cycle done strobe and reports how many cycles the jump took.

Bytes that do not belong to a jump are forwarded unchanged on an output byte stream, in the order they arrive. The input side is ready only while the unit is idle or holding a prefix, and only while its one-byte output buffer is empty. The output buffer keeps its byte and valid flag until the consumer accepts it, so a stalled consumer stalls the input. The pointer input is sampled on the clock edge that commits the jump. The base byte is loaded through a plain write strobe. The block has no condition-flag outputs, and no form of the jump changes any flags.

Top module: `ijmp_unit`

## Requirements
- R1: While rst is high on a clock edge, that edge sets the program counter to 0, the mode to 16-bit (mode_long = 0) and the base byte to 0. It also clears done and out_valid, so in_ready reads 1 after reset.
- R2: Opcode 0xE9 with no prefix in 16-bit mode replaces only pc[15:0] with ptr[15:0]. The mode stays 16-bit, and eff_addr reads {base, pc[15:0]}.
- R3: Opcode 0xE9 with no prefix in 24-bit mode loads all 24 pc bits from ptr. The mode stays 24-bit, and eff_addr equals pc.
- R4: Prefix 0x49 followed by 0xE9, issued in 16-bit mode, loads all 24 pc bits from ptr and sets mode_long to 1.
- R5: Prefix 0x52 followed by 0xE9, issued in 24-bit mode, replaces only pc[15:0] with ptr[15:0]. It clears mode_long to 0, and eff_addr then reads {base, pc[15:0]}.
- R6: Prefix 0x52 in 16-bit mode, or prefix 0x49 in 24-bit mode, gives the same pc and mode result as the unprefixed jump. It still reports 4 cycles.
- R7: cycles_used, valid while done is high, is 3 for the unprefixed jump and 4 for a prefixed one. When the bytes of the jump are accepted back to back, done goes high (cycles_used - 1) clock edges after the edge that accepted the first byte.
- R8: done is high for exactly one cycle per jump. pc and mode_long change only on the edge that raises done.
- R9: If a prefix byte is followed by any byte other than 0xE9, no jump is made. The prefix byte is forwarded on the output stream, its override is dropped, and the following byte is then handled as a fresh byte: it is forwarded, starts a new prefix, or is executed as an unprefixed jump.
- R10: Bytes that are neither 0xE9 nor one of the two prefixes are forwarded unchanged, in arrival order.
- R11: While out_valid is high and out_ready is low, out_valid stays high and out_data holds its value. While out_valid is high, in_ready is low.
- R12: A clock edge with base_we high loads base_din into the base byte. In 16-bit mode, eff_addr reflects the new base from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction byte valid |
| in_ready | output | 1 | Unit can accept an instruction byte |
| in_data | input | 8 | Instruction byte |
| ptr | input | 24 | Jump pointer register value, sampled on the commit edge |
| base_we | input | 1 | Load strobe for the base byte |
| base_din | input | 8 | New base byte value |
| out_valid | output | 1 | Forwarded byte valid |
| out_ready | input | 1 | Consumer accepts the forwarded byte |
| out_data | output | 8 | Forwarded non-jump byte |
| pc | output | 24 | Program counter |
| mode_long | output | 1 | 1 = 24-bit flat mode, 0 = 16-bit base-relative mode |
| eff_addr | output | 24 | Effective fetch address for the current mode |
| done | output | 1 | One-cycle strobe after pc and mode are updated |
| cycles_used | output | 3 | Cycle count of the jump just completed |

## Verification
The bound checker watches four things on every cycle: that done lasts one cycle, that pc and mode_long never change outside a done cycle, that cycles_used is one of the two legal counts, and the back-pressure rules on both streams. Some behaviour depends on which prefix came before the opcode and on the current mode, and only the bench's scenarios can show it. This covers the pc bits each form loads, the resulting mode, the effective address in each mode, the exact cycle at which done rises, and what happens to an abandoned prefix and to the bytes that follow it. The bench sweeps every prefix form from both modes across several pointer and base values.

// File: rtl/ijmp_pkg.sv
package ijmp_pkg;

  typedef enum logic [1:0] {
    OVR_NONE  = 2'd0,
    OVR_LONG  = 2'd1,
    OVR_SHORT = 2'd2
  } ovr_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_PFX    = 2'd1,
    ST_REPLAY = 2'd2,
    ST_EXEC   = 2'd3
  } seq_st_e;

  typedef struct packed {
    logic is_jump;
    logic is_long;
    logic is_short;
  } byte_cls_t;

endpackage

// File: rtl/ijmp_byte_class.sv
module ijmp_byte_class
  import ijmp_pkg::*;
#(
  parameter int                DATA_W   = 8,
  parameter logic [DATA_W-1:0] JUMP_OP  = 8'hE9,
  parameter logic [DATA_W-1:0] LONG_OP  = 8'h49,
  parameter logic [DATA_W-1:0] SHORT_OP = 8'h52
) (
  input  logic [DATA_W-1:0] byte_i,
  output byte_cls_t         cls_o
);

  always_comb begin
    cls_o.is_jump  = (byte_i == JUMP_OP);
    cls_o.is_long  = (byte_i == LONG_OP);
    cls_o.is_short = (byte_i == SHORT_OP);
  end

endmodule

// File: rtl/ijmp_target.sv
module ijmp_target
  import ijmp_pkg::*;
#(
  parameter int PC_W    = 24,
  parameter int SHORT_W = 16
) (
  input  logic [PC_W-1:0] pc_q,
  input  logic            long_q,
  input  ovr_e            ovr,
  input  logic [PC_W-1:0] ptr,
  output logic [PC_W-1:0] pc_nx,
  output logic            long_nx
);

  always_comb begin
    unique case (ovr)
      OVR_LONG:  long_nx = 1'b1;
      OVR_SHORT: long_nx = 1'b0;
      default:   long_nx = long_q;
    endcase
    if (long_nx) pc_nx = ptr;
    else         pc_nx = {pc_q[PC_W-1:SHORT_W], ptr[SHORT_W-1:0]};
  end

endmodule

// File: rtl/ijmp_seq.sv
module ijmp_seq
  import ijmp_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int BASE_CYCLES = 3,
  parameter int PFX_EXTRA   = 1,
  parameter int CYC_W       = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  byte_cls_t         cls_in,
  input  byte_cls_t         cls_held,
  input  logic              out_ready,
  output logic              in_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic [DATA_W-1:0] held_o,
  output logic              commit_o,
  output ovr_e              ovr_o,
  output logic [CYC_W-1:0]  cyc_o
);

  localparam int EXEC_LEN = BASE_CYCLES - 1;
  localparam int CNT_W    = (EXEC_LEN > 1) ? $clog2(EXEC_LEN) : 1;
  localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(EXEC_LEN - 1);
  localparam logic [CYC_W-1:0] CYC_PLAIN = CYC_W'(BASE_CYCLES);
  localparam logic [CYC_W-1:0] CYC_PFX   = CYC_W'(BASE_CYCLES + PFX_EXTRA);

  seq_st_e           st_q;
  ovr_e              ovr_q;
  logic [DATA_W-1:0] pfx_q;
  logic [DATA_W-1:0] held_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CYC_W-1:0]  cyc_q;
  logic              ov_q;
  logic [DATA_W-1:0] od_q;
  logic              acc;

  assign in_ready  = ((st_q == ST_IDLE) || (st_q == ST_PFX)) && !ov_q;
  assign acc       = in_valid && in_ready;
  assign out_valid = ov_q;
  assign out_data  = od_q;
  assign held_o    = held_q;
  assign commit_o  = (st_q == ST_EXEC) && (cnt_q == '0);
  assign ovr_o     = ovr_q;
  assign cyc_o     = cyc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      ovr_q  <= OVR_NONE;
      pfx_q  <= '0;
      held_q <= '0;
      cnt_q  <= '0;
      cyc_q  <= '0;
      ov_q   <= 1'b0;
      od_q   <= '0;
    end else begin
      if (ov_q && out_ready) ov_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (acc) begin
            if (cls_in.is_jump) begin
              st_q  <= ST_EXEC;
              ovr_q <= OVR_NONE;
              cnt_q <= CNT_INIT;
              cyc_q <= CYC_PLAIN;
            end else if (cls_in.is_long || cls_in.is_short) begin
              st_q  <= ST_PFX;
              ovr_q <= cls_in.is_long ? OVR_LONG : OVR_SHORT;
              pfx_q <= in_data;
            end else begin
              ov_q <= 1'b1;
              od_q <= in_data;
            end
          end
        end
        ST_PFX: begin
          if (acc) begin
            if (cls_in.is_jump) begin
              st_q  <= ST_EXEC;
              cnt_q <= CNT_INIT;
              cyc_q <= CYC_PFX;
            end else begin
              ov_q   <= 1'b1;
              od_q   <= pfx_q;
              held_q <= in_data;
              ovr_q  <= OVR_NONE;
              st_q   <= ST_REPLAY;
            end
          end
        end
        ST_REPLAY: begin
          if (cls_held.is_jump) begin
            st_q  <= ST_EXEC;
            ovr_q <= OVR_NONE;
            cnt_q <= CNT_INIT;
            cyc_q <= CYC_PLAIN;
          end else if (cls_held.is_long || cls_held.is_short) begin
            st_q  <= ST_PFX;
            ovr_q <= cls_held.is_long ? OVR_LONG : OVR_SHORT;
            pfx_q <= held_q;
          end else if (!ov_q) begin
            ov_q <= 1'b1;
            od_q <= held_q;
            st_q <= ST_IDLE;
          end
        end
        default: begin
          if (cnt_q == '0) st_q <= ST_IDLE;
          else             cnt_q <= cnt_q - 1'b1;
        end
      endcase
    end
  end

endmodule

// File: rtl/ijmp_unit.sv
module ijmp_unit
  import ijmp_pkg::*;
#(
  parameter int                DATA_W      = 8,
  parameter int                PC_W        = 24,
  parameter int                SHORT_W     = 16,
  parameter int                BASE_CYCLES = 3,
  parameter int                PFX_EXTRA   = 1,
  parameter logic [DATA_W-1:0] JUMP_OP     = 8'hE9,
  parameter logic [DATA_W-1:0] LONG_OP     = 8'h49,
  parameter logic [DATA_W-1:0] SHORT_OP    = 8'h52,
  localparam int               BASE_W      = PC_W - SHORT_W,
  localparam int               CYC_W       = $clog2(BASE_CYCLES + PFX_EXTRA + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [PC_W-1:0]   ptr,
  input  logic              base_we,
  input  logic [BASE_W-1:0] base_din,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [PC_W-1:0]   pc,
  output logic              mode_long,
  output logic [PC_W-1:0]   eff_addr,
  output logic              done,
  output logic [CYC_W-1:0]  cycles_used
);

  logic [DATA_W-1:0] held;
  logic [DATA_W-1:0] cls_src [2];
  byte_cls_t         cls     [2];
  logic              commit;
  ovr_e              ovr;
  logic [CYC_W-1:0]  cyc;
  logic [PC_W-1:0]   pc_q, pc_nx;
  logic              long_q, long_nx;
  logic [BASE_W-1:0] base_q;
  logic              done_q;
  logic [CYC_W-1:0]  cyc_out_q;

  always_comb begin
    cls_src[0] = in_data;
    cls_src[1] = held;
  end

  for (genvar gi = 0; gi < 2; gi++) begin : g_cls
    ijmp_byte_class #(
      .DATA_W(DATA_W), .JUMP_OP(JUMP_OP), .LONG_OP(LONG_OP), .SHORT_OP(SHORT_OP)
    ) u_cls (
      .byte_i(cls_src[gi]),
      .cls_o (cls[gi])
    );
  end

  ijmp_seq #(
    .DATA_W(DATA_W), .BASE_CYCLES(BASE_CYCLES), .PFX_EXTRA(PFX_EXTRA), .CYC_W(CYC_W)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_data  (in_data),
    .cls_in   (cls[0]),
    .cls_held (cls[1]),
    .out_ready(out_ready),
    .in_ready (in_ready),
    .out_valid(out_valid),
    .out_data (out_data),
    .held_o   (held),
    .commit_o (commit),
    .ovr_o    (ovr),
    .cyc_o    (cyc)
  );

  ijmp_target #(.PC_W(PC_W), .SHORT_W(SHORT_W)) u_tgt (
    .pc_q   (pc_q),
    .long_q (long_q),
    .ovr    (ovr),
    .ptr    (ptr),
    .pc_nx  (pc_nx),
    .long_nx(long_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q      <= '0;
      long_q    <= 1'b0;
      base_q    <= '0;
      done_q    <= 1'b0;
      cyc_out_q <= '0;
    end else begin
      done_q <= commit;
      if (commit) begin
        pc_q      <= pc_nx;
        long_q    <= long_nx;
        cyc_out_q <= cyc;
      end
      if (base_we) base_q <= base_din;
    end
  end

  assign pc          = pc_q;
  assign mode_long   = long_q;
  assign done        = done_q;
  assign cycles_used = cyc_out_q;
  assign eff_addr    = long_q ? pc_q : {base_q, pc_q[SHORT_W-1:0]};

endmodule

// File: rtl/ijmp_unit_checker.sv
module ijmp_unit_checker #(
  parameter int DATA_W      = 8,
  parameter int PC_W        = 24,
  parameter int BASE_CYCLES = 3,
  parameter int PFX_EXTRA   = 1,
  parameter int CYC_W       = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic [PC_W-1:0]   pc,
  input logic              mode_long,
  input logic              done,
  input logic [CYC_W-1:0]  cycles_used
);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_mode_only_on_done_R8: assert property (@(posedge clk) disable iff (rst)
    !$stable(mode_long) |-> done);

  assert_pc_only_on_done_R8: assert property (@(posedge clk) disable iff (rst)
    !$stable(pc) |-> done);

  assert_cycle_count_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> (cycles_used == CYC_W'(BASE_CYCLES)) ||
             (cycles_used == CYC_W'(BASE_CYCLES + PFX_EXTRA)));

  assert_out_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_no_accept_full_R11: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready);

endmodule

bind ijmp_unit ijmp_unit_checker #(
  .DATA_W(DATA_W), .PC_W(PC_W), .BASE_CYCLES(BASE_CYCLES),
  .PFX_EXTRA(PFX_EXTRA), .CYC_W(CYC_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_data   (out_data),
  .pc         (pc),
  .mode_long  (mode_long),
  .done       (done),
  .cycles_used(cycles_used)
);

// File: tb/ijmp_unit_bench.sv
module ijmp_unit_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = 8'h00;
  logic [23:0] ptr = '0;
  logic        base_we = 1'b0;
  logic [7:0]  base_din = 8'h00;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [7:0]  out_data;
  logic [23:0] pc;
  logic        mode_long;
  logic [23:0] eff_addr;
  logic        done;
  logic [2:0]  cycles_used;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  logic [7:0] obuf [64];
  int ocnt = 0;

  logic [23:0] m_pc   = '0;
  logic        m_long = 1'b0;
  logic [7:0]  m_base = '0;

  ijmp_unit u_ijmp_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .ptr(ptr), .base_we(base_we), .base_din(base_din), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .pc(pc), .mode_long(mode_long),
    .eff_addr(eff_addr), .done(done), .cycles_used(cycles_used)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    #2;
    if (out_valid && out_ready && ocnt < 64) begin
      obuf[ocnt] = out_data;
      ocnt = ocnt + 1;
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  always @(negedge clk) begin
    if (cyc > 150000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run hung (actual cycle %0d, expected < 150000)", cyc);
      finish_run();
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] m_eff();
    return m_long ? m_pc : {m_base, m_pc[15:0]};
  endfunction

  task automatic send_byte(input logic [7:0] b, output int acc);
    in_valid = 1'b1;
    in_data  = b;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    acc = cyc;
    in_valid = 1'b0;
  endtask

  task automatic load_base(input logic [7:0] v);
    base_we  = 1'b1;
    base_din = v;
    @(negedge clk);
    base_we = 1'b0;
    m_base  = v;
  endtask

  // kind: 0 = no prefix, 1 = long prefix 0x49, 2 = short prefix 0x52
  task automatic jump(input int kind, input logic [23:0] p);
    int a0, a1, waitc;
    logic        n_long;
    logic [23:0] n_pc;
    string       req;
    n_long = (kind == 1) ? 1'b1 : (kind == 2) ? 1'b0 : m_long;
    n_pc   = n_long ? p : {m_pc[23:16], p[15:0]};
    if (kind == 0)                 req = m_long ? "R3" : "R2";
    else if (kind == 1 && !m_long) req = "R4";
    else if (kind == 2 &&  m_long) req = "R5";
    else                           req = "R6";
    ptr = p;
    a0 = 0;
    if (kind == 1) send_byte(8'h49, a0);
    if (kind == 2) send_byte(8'h52, a0);
    send_byte(8'hE9, a1);
    if (kind == 0) a0 = a1;
    waitc = 0;
    while (!done && waitc < 20) begin
      @(negedge clk);
      waitc++;
    end
    chk("R7 done", 32'(done), 32'd1);
    chk("R7 cycles", 32'(cycles_used), (kind == 0) ? 32'd3 : 32'd4);
    chk("R7 timing", 32'(cyc - a0), (kind == 0) ? 32'd2 : 32'd3);
    m_pc = n_pc;
    m_long = n_long;
    chk({req, " pc"}, 32'(pc), 32'(m_pc));
    chk({req, " mode"}, 32'(mode_long), 32'(m_long));
    chk({req, " eff"}, 32'(eff_addr), 32'(m_eff()));
    @(negedge clk);
    chk("R8 strobe", 32'(done), 32'd0);
  endtask

  initial begin
    int acc;
    logic [23:0] p;
    logic [7:0]  bases [3];
    int o0;
    bases[0] = 8'h00; bases[1] = 8'hA5; bases[2] = 8'hFF;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 pc", 32'(pc), 32'd0);
    chk("R1 mode", 32'(mode_long), 32'd0);
    chk("R1 eff", 32'(eff_addr), 32'd0);
    chk("R1 done", 32'(done), 32'd0);
    chk("R1 in_ready", 32'(in_ready), 32'd1);
    chk("R1 out_valid", 32'(out_valid), 32'd0);

    // R12: base byte load visible through eff_addr in 16-bit mode
    load_base(8'h3C);
    chk("R12 eff", 32'(eff_addr), 32'(m_eff()));

    // Sweep every form from both start modes over several bases and pointers
    for (int bi = 0; bi < 3; bi++) begin
      load_base(bases[bi]);
      for (int sm = 0; sm < 2; sm++) begin
        for (int k = 0; k < 3; k++) begin
          for (int pi = 0; pi < 6; pi++) begin
            p = 24'(pi * 32'h2B7D13) ^ 24'(bi * 32'h91C5A7) ^ ((pi == 5) ? 24'hFFFFFF : 24'h0);
            if (m_long != sm[0]) jump(sm[0] ? 1 : 2, 24'(32'h10F0E1 * (pi + 1)));
            jump(k, p);
          end
        end
      end
    end

    // R10: plain bytes are forwarded in order
    if (m_long) jump(2, 24'h00ABCD);
    o0 = ocnt;
    send_byte(8'h00, acc);
    send_byte(8'h7E, acc);
    repeat (3) @(negedge clk);
    chk("R10 count", 32'(ocnt - o0), 32'd2);
    chk("R10 byte0", 32'(obuf[o0]), 32'h00);
    chk("R10 byte1", 32'(obuf[o0 + 1]), 32'h7E);

    // R9: prefix followed by a non-jump byte
    o0 = ocnt;
    send_byte(8'h49, acc);
    send_byte(8'h12, acc);
    repeat (4) @(negedge clk);
    chk("R9 count", 32'(ocnt - o0), 32'd2);
    chk("R9 prefix out", 32'(obuf[o0]), 32'h49);
    chk("R9 byte out", 32'(obuf[o0 + 1]), 32'h12);
    chk("R9 pc kept", 32'(pc), 32'(m_pc));
    chk("R9 mode kept", 32'(mode_long), 32'(m_long));
    chk("R9 no done", 32'(done), 32'd0);

    // R9: abandoned prefix followed by a second prefix and the jump
    o0 = ocnt;
    ptr = 24'h5A6B7C;
    send_byte(8'h52, acc);
    send_byte(8'h49, acc);
    send_byte(8'hE9, acc);
    while (!done && cyc < 140000) @(negedge clk);
    m_pc = 24'h5A6B7C;
    m_long = 1'b1;
    chk("R9 chained pc", 32'(pc), 32'(m_pc));
    chk("R9 chained mode", 32'(mode_long), 32'd1);
    chk("R9 chained cycles", 32'(cycles_used), 32'd4);
    @(negedge clk);
    chk("R9 chained out", 32'(obuf[o0]), 32'h52);
    chk("R9 chained count", 32'(ocnt - o0), 32'd1);

    // R9: prefix then plain byte replay then jump executes unprefixed
    ptr = 24'h0F1E2D;
    send_byte(8'h52, acc);
    send_byte(8'hE9 ^ 8'h01, acc);
    send_byte(8'hE9, acc);
    while (!done && cyc < 140000) @(negedge clk);
    m_pc = 24'h0F1E2D;
    chk("R9 replay pc", 32'(pc), 32'(m_pc));
    chk("R9 replay mode", 32'(mode_long), 32'd1);
    chk("R9 replay cycles", 32'(cycles_used), 32'd3);
    @(negedge clk);

    // R11: back-pressure on the output stream
    out_ready = 1'b0;
    o0 = ocnt;
    send_byte(8'h33, acc);
    in_valid = 1'b1;
    in_data  = 8'h44;
    for (int w = 0; w < 4; w++) begin
      chk("R11 hold valid", 32'(out_valid), 32'd1);
      chk("R11 hold data", 32'(out_data), 32'h33);
      chk("R11 in_ready low", 32'(in_ready), 32'd0);
      @(negedge clk);
    end
    in_valid = 1'b0;
    out_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11 drained", 32'(ocnt - o0), 32'd1);
    chk("R11 drained byte", 32'(obuf[o0]), 32'h33);

    // R12: base change while in 16-bit mode
    jump(2, 24'h123456);
    load_base(8'hC3);
    chk("R12 eff new base", 32'(eff_addr), 32'(m_eff()));

    finish_run();
  end

endmodule